// File: doc/BRIEF.md
# Branch Decode and Link Writeback

This unit takes one branch instruction of a SIMD core, given as two 32-bit words, and works out two things. The first is where control goes: whether the branch is taken and what its target address is. The second is what the branch writes back: the return link and the target, each sent to the register file through its own write port. The low word holds an absolute address or a signed offset. The high word holds the opcode, the condition selector, the addressing mode bits, a bank-A register index, a crossover bit and the two write addresses.

The unit is a single registered stage. When an input instruction is valid and carries the branch opcode, every result appears together on the next clock with a one-cycle valid strobe. For register-relative targets the unit drives a bank-A read index straight from the instruction word, without a register. The register file returns that data in the same cycle, and the unit adds it to the target. The write ports follow a fixed pairing. The add-path port carries the link, and the multiply-path port carries the computed target. The crossover bit chooses which of the two register banks each port writes.

Top module: `branch_link_unit`

## Requirements
- R1: While rstN is low and on the first clock after it rises, outValid, taken, target, both write enables, both bank selects, both write addresses and both write data outputs are all zero.
- R2: outValid goes high for exactly the clock after a cycle in which instValid is high and instHi[31:28] equals 4'b1111. After any other cycle it is low, and so are taken and both write enables. In that case target, the bank selects, the write addresses and the write data hold their previous values.
- R3: taken equals condFlags[instHi[23:20]]. The 4-bit condition field picks one bit of the 16-bit flag vector.
- R4: When instHi[19] is 0 (absolute mode), target equals instLo, plus the register term of R6.
- R5: When instHi[19] is 1 (relative mode), target equals pcIn + instLo + 32, taken modulo 2^32, plus the register term of R6.
- R6: rdAddrA always equals instHi[17:13]. When instHi[18] is 1, the rdDataA value present with the instruction is added to the target. When instHi[18] is 0, rdDataA has no effect.
- R7: The add-path port writes address instHi[11:6] with data pcIn + 32. addWrBank equals the crossover bit instHi[12] (0 = bank A, 1 = bank B).
- R8: The multiply-path port writes address instHi[5:0] with data equal to the target. mulWrBank is the inverse of instHi[12].
- R9: A write address field equal to 39 turns off that port's write enable and leaves the other port unaffected.
- R10: A branch that is not taken still raises outValid and reports its target, but both write enables stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction words are valid this cycle |
| instLo | input | 32 | Low word: absolute address or offset |
| instHi | input | 32 | High word: opcode, condition, mode bits, register index, crossover, write addresses |
| pcIn | input | 32 | Address of the branch instruction |
| condFlags | input | 16 | One flag bit per condition code |
| rdAddrA | output | 5 | Bank-A read index for the register term |
| rdDataA | input | 32 | Bank-A read data for that index |
| outValid | output | 1 | One-cycle strobe for a decoded branch |
| taken | output | 1 | Branch condition is met |
| target | output | 32 | Branch target address |
| addWrEn | output | 1 | Add-path write enable |
| addWrBank | output | 1 | Add-path bank select (1 = bank B) |
| addWrAddr | output | 6 | Add-path write address |
| addWrData | output | 32 | Add-path write data (return link) |
| mulWrEn | output | 1 | Multiply-path write enable |
| mulWrBank | output | 1 | Multiply-path bank select (1 = bank B) |
| mulWrAddr | output | 6 | Multiply-path write address |
| mulWrData | output | 32 | Multiply-path write data (target) |

## Verification
The bench goes after the crossover bit in both states, because a design that wires the bank selects straight through would send the link into the wrong bank whenever X is set. It places the null address 39 on each port in turn, and with the branch both taken and not taken. A wrong gate here would either clobber a register or drop a real link write. It drives relative targets whose sum wraps past 2^32, so a design that forgets the 32-byte offset or widens the sum will miscompare. It also drives random rdDataA while the register-add bit is clear, which exposes a design that adds that data without checking the bit. Non-branch opcodes and idle cycles between branches are mixed in, so that a strobe that stays high, or data that fails to hold, is caught.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int REG_W     = 5;
  localparam int COND_W    = 4;
  localparam int FLAG_N    = 1 << COND_W;
  localparam int NULL_ADDR = 39;
  localparam int LINK_OFS  = 32;
  localparam logic [3:0] BR_OPCODE = 4'b1111;

  typedef struct packed {
    logic load;     // latch a new branch result
    logic relMode;  // target relative to PC
    logic addReg;   // add bank-A register value
  } dpStrobe_t;
endpackage

// File: rtl/blu_ctrl.sv
module blu_ctrl
  import blu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [DATA_W-1:0]   instHi,
  input  logic [FLAG_N-1:0]   condFlags,
  output dpStrobe_t           strobes,
  output logic [REG_W-1:0]    rdAddrA,
  output logic                outValid,
  output logic                taken,
  output logic [1:0]          portEn,
  output logic [1:0]          portBank,
  output logic [ADDR_W-1:0]   portAddr [2]
);
  logic isBranch;
  logic condHit;
  logic crossX;
  logic [COND_W-1:0] condSel;
  logic [ADDR_W-1:0] fieldAddr [2];
  logic unusedHi;

  assign isBranch     = instValid && (instHi[31:28] == BR_OPCODE);
  assign condSel      = instHi[23:20];
  assign condHit      = condFlags[condSel];
  assign crossX       = instHi[12];
  assign fieldAddr[0] = instHi[11:6];
  assign fieldAddr[1] = instHi[5:0];
  assign rdAddrA      = instHi[17:13];
  assign unusedHi     = ^instHi[27:24];

  assign strobes.load    = isBranch;
  assign strobes.relMode = instHi[19];
  assign strobes.addReg  = instHi[18];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
    end else begin
      outValid <= isBranch;
      taken    <= isBranch && condHit;
    end
  end

  // port 0 = add path (link), port 1 = multiply path (target)
  for (genvar p = 0; p < 2; p++) begin : g_port
    logic bankSel;
    assign bankSel = (p == 0) ? crossX : !crossX;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        portEn[p]   <= 1'b0;
        portBank[p] <= 1'b0;
        portAddr[p] <= '0;
      end else begin
        portEn[p] <= isBranch && condHit && (fieldAddr[p] != ADDR_W'(NULL_ADDR));
        if (isBranch) begin
          portBank[p] <= bankSel;
          portAddr[p] <= fieldAddr[p];
        end
      end
    end
  end

  p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    isBranch |=> outValid);
  p_quiet_after_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !isBranch |=> (!outValid && portEn == 2'b00));
  p_no_write_untaken_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !taken) |-> (portEn == 2'b00));
  p_null_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    portEn[0] |-> (portAddr[0] != ADDR_W'(NULL_ADDR)));
  p_banks_apart_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (portBank[0] != portBank[1]));
endmodule

// File: rtl/blu_datapath.sv
module blu_datapath
  import blu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobes,
  input  logic [DATA_W-1:0]  instLo,
  input  logic [DATA_W-1:0]  pcIn,
  input  logic [DATA_W-1:0]  rdDataA,
  output logic [DATA_W-1:0]  target,
  output logic [DATA_W-1:0]  linkVal
);
  logic [DATA_W-1:0] aheadPc;
  logic [DATA_W-1:0] baseAddr;
  logic [DATA_W-1:0] regTerm;
  logic [DATA_W-1:0] nextTarget;

  assign aheadPc    = pcIn + DATA_W'(LINK_OFS);
  assign baseAddr   = strobes.relMode ? (aheadPc + instLo) : instLo;
  assign regTerm    = strobes.addReg ? rdDataA : '0;
  assign nextTarget = baseAddr + regTerm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      target  <= '0;
      linkVal <= '0;
    end else if (strobes.load) begin
      target  <= nextTarget;
      linkVal <= aheadPc;
    end
  end

  p_link_ahead_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (linkVal == $past(pcIn) + DATA_W'(LINK_OFS)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(target));
endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
  import blu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instValid,
  input  logic [31:0]  instLo,
  input  logic [31:0]  instHi,
  input  logic [31:0]  pcIn,
  input  logic [15:0]  condFlags,
  output logic [4:0]   rdAddrA,
  input  logic [31:0]  rdDataA,
  output logic         outValid,
  output logic         taken,
  output logic [31:0]  target,
  output logic         addWrEn,
  output logic         addWrBank,
  output logic [5:0]   addWrAddr,
  output logic [31:0]  addWrData,
  output logic         mulWrEn,
  output logic         mulWrBank,
  output logic [5:0]   mulWrAddr,
  output logic [31:0]  mulWrData
);
  dpStrobe_t strobes;
  logic [1:0] portEn;
  logic [1:0] portBank;
  logic [ADDR_W-1:0] portAddr [2];
  logic [DATA_W-1:0] linkVal;

  blu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instHi(instHi),
    .condFlags(condFlags), .strobes(strobes), .rdAddrA(rdAddrA),
    .outValid(outValid), .taken(taken), .portEn(portEn),
    .portBank(portBank), .portAddr(portAddr)
  );

  blu_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instLo(instLo),
    .pcIn(pcIn), .rdDataA(rdDataA), .target(target), .linkVal(linkVal)
  );

  assign addWrEn   = portEn[0];
  assign addWrBank = portBank[0];
  assign addWrAddr = portAddr[0];
  assign addWrData = linkVal;
  assign mulWrEn   = portEn[1];
  assign mulWrBank = portBank[1];
  assign mulWrAddr = portAddr[1];
  assign mulWrData = target;

  p_enable_needs_taken_r10: assert property (@(posedge clk) disable iff (!rstN)
    (addWrEn || mulWrEn) |-> (taken && outValid));
  p_mul_carries_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    mulWrEn |-> (mulWrData == target));
endmodule

// File: tb/branch_link_unit_test.sv
module branch_link_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instValid = 1'b0;
  logic [31:0] instLo = '0, instHi = '0, pcIn = '0;
  logic [15:0] condFlags = '0;
  logic [4:0]  rdAddrA;
  logic [31:0] rdDataA;
  logic outValid, taken, addWrEn, addWrBank, mulWrEn, mulWrBank;
  logic [31:0] target, addWrData, mulWrData;
  logic [5:0]  addWrAddr, mulWrAddr;

  logic [31:0] regFile [32];
  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  // expected outputs
  logic eValid = 0, eTaken = 0, eAddEn = 0, eMulEn = 0, eAddBank = 0, eMulBank = 0;
  logic [31:0] eTarget = '0, eAddData = '0, eMulData = '0;
  logic [5:0]  eAddAddr = '0, eMulAddr = '0;

  always #4 clk = ~clk;   // 125 MHz

  assign rdDataA = regFile[rdAddrA];

  branch_link_unit uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instLo(instLo),
    .instHi(instHi), .pcIn(pcIn), .condFlags(condFlags), .rdAddrA(rdAddrA),
    .rdDataA(rdDataA), .outValid(outValid), .taken(taken), .target(target),
    .addWrEn(addWrEn), .addWrBank(addWrBank), .addWrAddr(addWrAddr),
    .addWrData(addWrData), .mulWrEn(mulWrEn), .mulWrBank(mulWrBank),
    .mulWrAddr(mulWrAddr), .mulWrData(mulWrData)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2", "outValid", 32'(outValid), 32'(eValid));
    chk("R3", "taken", 32'(taken), 32'(eTaken));
    chk("R4/R5", "target", target, eTarget);
    chk("R9", "addWrEn", 32'(addWrEn), 32'(eAddEn));
    chk("R9", "mulWrEn", 32'(mulWrEn), 32'(eMulEn));
    chk("R7", "addWrBank", 32'(addWrBank), 32'(eAddBank));
    chk("R8", "mulWrBank", 32'(mulWrBank), 32'(eMulBank));
    chk("R7", "addWrAddr", 32'(addWrAddr), 32'(eAddAddr));
    chk("R8", "mulWrAddr", 32'(mulWrAddr), 32'(eMulAddr));
    chk("R7", "addWrData", addWrData, eAddData);
    chk("R8", "mulWrData", mulWrData, eMulData);
  endtask

  function automatic logic [31:0] mkHi(logic [3:0] op, logic [3:0] cond, logic rel,
      logic rAdd, logic [4:0] ra, logic x, logic [5:0] wa, logic [5:0] wb);
    return {op, 4'h0, cond, rel, rAdd, ra, x, wa, wb};
  endfunction

  // drive one cycle at negedge, after checking the previous cycle's result
  task automatic step(logic v, logic [31:0] lo, logic [31:0] hi, logic [31:0] pc,
      logic [15:0] flags);
    logic [31:0] tgt;
    logic tk;
    @(negedge clk);
    compareAll();
    instValid = v; instLo = lo; instHi = hi; pcIn = pc; condFlags = flags;
    #1;
    chk("R6", "rdAddrA", 32'(rdAddrA), 32'(hi[17:13]));
    if (v && hi[31:28] == 4'hF) begin
      tk  = flags[hi[23:20]];
      tgt = hi[19] ? pc + lo + 32'd32 : lo;
      if (hi[18]) tgt = tgt + regFile[hi[17:13]];
      eValid = 1; eTaken = tk; eTarget = tgt;
      eAddAddr = hi[11:6]; eMulAddr = hi[5:0];
      eAddBank = hi[12]; eMulBank = !hi[12];
      eAddEn = tk && hi[11:6] != 6'd39;
      eMulEn = tk && hi[5:0] != 6'd39;
      eAddData = pc + 32'd32; eMulData = tgt;
    end else begin
      eValid = 0; eTaken = 0; eAddEn = 0; eMulEn = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regFile[i] = 32'h1000_0000 * (i % 16) + 32'(i * 77);
    repeat (3) @(negedge clk);
    compareAll();                          // R1 during reset
    @(negedge clk); rstN = 1;
    @(posedge clk);
    // R3 taken; R4 absolute, X=0
    step(1, 32'h0000_4000, mkHi(4'hF, 4'd2, 0, 0, 5'd0, 0, 6'd4, 6'd39), 32'h100, 16'h0004);
    // R7 crossover X=1 with link via wa
    step(1, 32'h0000_0038, mkHi(4'hF, 4'd0, 1, 0, 5'd0, 1, 6'd4, 6'd39), 32'h210, 16'h0001);
    // R10 not taken
    step(1, 32'h0000_0100, mkHi(4'hF, 4'd5, 1, 0, 5'd0, 0, 6'd7, 6'd9), 32'h400, 16'hFFDF);
    // R2 idle: values hold
    step(0, 32'hDEAD_BEEF, mkHi(4'hF, 4'd0, 0, 0, 5'd0, 0, 6'd1, 6'd2), 32'h0, 16'hFFFF);
    // R2 wrong opcode
    step(1, 32'h1234_5678, mkHi(4'hE, 4'd0, 0, 0, 5'd0, 0, 6'd1, 6'd2), 32'h0, 16'hFFFF);
    // R5 relative wrap past 2^32
    step(1, 32'hFFFF_FFF0, mkHi(4'hF, 4'd15, 1, 0, 5'd0, 0, 6'd3, 6'd5), 32'h40, 16'h8000);
    // R6 register add
    step(1, 32'h0000_0010, mkHi(4'hF, 4'd1, 0, 1, 5'd17, 1, 6'd10, 6'd11), 32'h80, 16'h0002);
    // R6 register present but bit clear: no effect
    step(1, 32'h0000_0010, mkHi(4'hF, 4'd1, 0, 0, 5'd17, 1, 6'd10, 6'd11), 32'h80, 16'h0002);
    // R9 null on multiply port only, and on add port only
    step(1, 32'h20, mkHi(4'hF, 4'd3, 0, 0, 5'd0, 0, 6'd12, 6'd39), 32'h0, 16'h0008);
    step(1, 32'h24, mkHi(4'hF, 4'd3, 0, 0, 5'd0, 1, 6'd39, 6'd13), 32'h0, 16'h0008);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] hi;
      hi = $urandom;
      if (n % 5 != 0) hi[31:28] = 4'hF;
      if (n % 7 == 0) hi[11:6] = 6'd39;
      if (n % 11 == 0) hi[5:0] = 6'd39;
      step(($urandom % 6) != 0, $urandom, hi, $urandom, 16'($urandom));
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule